// File: doc/BRIEF.md
# Host Controller Interrupt Delivery Router

This block sits between a bank of host-controller interrupters and the ways in which an interrupt can leave the device. Each interrupter raises or lowers a request. The router then drives a level-sensitive legacy pin, issues a one-cycle MSI-X vector message request, or issues an MSI vector message request. The choice depends on which message capability software has enabled. When MSI-X is enabled it takes priority over MSI. When neither is enabled the router is in pin mode, and in pin mode only interrupter 0 can reach the outside.

Message requests are registered and leave one per cycle, with the lowest interrupter index served first. The block also keeps a per-vector in-use bitmap for MSI-X, and it works out which interrupter an event should actually be steered to. A steering option, off after reset, makes every event land on interrupter 0 whenever the device is in pin mode.

Top module: `irq_router`

## Requirements
- R1: In pin mode (MSI-X and MSI both disabled), a request from interrupter 0 loads its level into `irq_pin` one cycle later, so a low level clears the pin. Requests from any other interrupter leave the pin unchanged and produce no message.
- R2: With MSI-X enabled, an asserted request from interrupter i produces a message for vector i. This holds even when MSI is also enabled.
- R3: With only MSI enabled, the vector is i modulo 2^`msi_vec_log2`. The field values 0 to 5 select 1 to 32 vectors, and larger values behave as 5.
- R4: `raise_delivered[i]` is high in the same cycle exactly when interrupter i pulses with a high level while MSI-X or MSI is enabled. A pulse with a low level is not delivered and produces no message.
- R5: `msg_valid` rises in the cycle after an asserted request and lasts one cycle per request. Requests from several interrupters in the same cycle leave in ascending index order, one per cycle.
- R6: When `intr_count` is 1, `eff_target` is 0 whatever `evt_target` holds.
- R7: When the conditional-steering bit is 1, `eff_target` is 0 in pin mode. While MSI-X or MSI is enabled, `eff_target` equals `evt_target` (provided `intr_count` > 1).
- R8: The conditional-steering bit is 0 after reset, so `eff_target` follows `evt_target` in pin mode. The bit is written from `cfg_cond_map` on a cycle with `cfg_we` high.
- R9: `vec_in_use[idx]` takes the value of `use_enable` on a `use_valid` cycle only while MSI-X is enabled. A request that matches the current bit, or any request made while MSI-X is disabled, changes nothing.
- R10: Synchronous active-low reset clears `irq_pin`, `vec_in_use`, `msg_valid` and any queued message requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msix_en | input | 1 | MSI-X capability enabled |
| msi_en | input | 1 | MSI capability enabled |
| msi_vec_log2 | input | 3 | log2 of the number of allocated MSI vectors (0..5) |
| intr_count | input | IDX_W+1 | Number of implemented interrupters |
| cfg_we | input | 1 | Write strobe for the conditional-steering bit |
| cfg_cond_map | input | 1 | New value of the conditional-steering bit |
| raise_pulse | input | NUM_INTR | Per-interrupter request strobe for this cycle |
| raise_level | input | NUM_INTR | Per-interrupter request level paired with the strobe |
| raise_delivered | output | NUM_INTR | Request accepted for message delivery |
| irq_pin | output | 1 | Legacy level-sensitive interrupt pin |
| msg_valid | output | 1 | One-cycle message request strobe |
| msg_vector | output | IDX_W | Vector number of the message request |
| use_valid | input | 1 | In-use update strobe |
| use_idx | input | IDX_W | Vector addressed by the in-use update |
| use_enable | input | 1 | 1 marks the vector used, 0 marks it unused |
| vec_in_use | output | NUM_INTR | MSI-X per-vector in-use bitmap |
| evt_target | input | IDX_W | Requested target interrupter of an event |
| eff_target | output | IDX_W | Interrupter the event is steered to |

## Verification
The assertions assume that `msi_vec_log2` and both enable bits do not change in the cycle a message is picked. They also assume that `use_idx` is always below NUM_INTR. The stimulus changes modes only after every expected message has drained from the scoreboard queue, and it uses only valid vector indices. Request bursts are kept short, so that ordering can be checked without a new request overtaking one already queued.

// File: rtl/irq_router_pkg.sv
// Package: shared delivery-mode type and the helper that chooses the mode.
// Assumes: MSI-X has priority over MSI; neither enabled means pin mode.
package irq_router_pkg;

    typedef enum logic [1:0] {
        DLV_PIN  = 2'd0,
        DLV_MSIX = 2'd1,
        DLV_MSI  = 2'd2
    } dlv_mode_e;

    localparam int MSI_LOG2_MAX = 5;

    // Choose the delivery mode from the two capability enables.
    function automatic dlv_mode_e pick_mode(input logic msix_on, input logic msi_on);
        if (msix_on)     return DLV_MSIX;
        else if (msi_on) return DLV_MSI;
        else             return DLV_PIN;
    endfunction

endpackage

// File: rtl/irq_msg_arb.sv
// Module: collects accepted message requests, serves the lowest index first,
// and registers a one-cycle strobe with the vector number.
// Assumes: mode and msi_mask are stable while requests are queued.
module irq_msg_arb
    import irq_router_pkg::*;
#(
    parameter int NUM_INTR = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dlv_mode_e           mode,
    input  logic [IDX_W-1:0]    msi_mask,
    input  logic [NUM_INTR-1:0] new_req,
    output logic                msg_valid,
    output logic [IDX_W-1:0]    msg_vector
);

    logic [NUM_INTR-1:0] pending_q;
    logic [NUM_INTR-1:0] cand;
    logic [NUM_INTR-1:0] grant;
    logic [IDX_W-1:0]    sel_idx;
    logic                found;
    logic                started_q;

    // Pick the lowest-index request among queued and newly accepted ones.
    always_comb begin
        cand    = pending_q | new_req;
        grant   = '0;
        sel_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_INTR; i++) begin
            if (cand[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                sel_idx  = IDX_W'(i);
            end
        end
    end

    // Update the queue and register the strobe and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q  <= '0;
            msg_valid  <= 1'b0;
            msg_vector <= '0;
        end else if (mode == DLV_PIN) begin
            pending_q  <= '0;
            msg_valid  <= 1'b0;
        end else begin
            pending_q  <= cand & ~grant;
            msg_valid  <= found;
            if (found)
                msg_vector <= (mode == DLV_MSIX) ? sel_idx : (sel_idx & msi_mask);
        end
    end

    // Track that a reset cycle has been seen, for the assertions below.
    always_ff @(posedge clk) started_q <= started_q | !rst_n;

    assert_strobe_mode_R4: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        msg_valid |-> $past(mode != DLV_PIN));

    assert_msi_range_R3: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        (msg_valid && $past(mode == DLV_MSI)) |-> ((msg_vector & ~$past(msi_mask)) == '0));

    assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        $onehot0(grant));

    assert_pin_silent_R1: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        $past(mode == DLV_PIN) |-> !msg_valid);

endmodule

// File: rtl/irq_vec_use.sv
// Module: per-vector MSI-X in-use bitmap.
// Assumes: use_idx is below NUM_INTR; updates are accepted only while MSI-X is on.
module irq_vec_use #(
    parameter int NUM_INTR = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msix_on,
    input  logic                use_valid,
    input  logic [IDX_W-1:0]    use_idx,
    input  logic                use_enable,
    output logic [NUM_INTR-1:0] in_use
);

    logic started_q;

    // Apply a use/unuse request when MSI-X is on and the state differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_use <= '0;
        end else if (msix_on && use_valid) begin
            for (int i = 0; i < NUM_INTR; i++) begin
                if (use_idx == IDX_W'(i) && in_use[i] != use_enable)
                    in_use[i] <= use_enable;
            end
        end
    end

    // Track that a reset cycle has been seen, for the assertions below.
    always_ff @(posedge clk) started_q <= started_q | !rst_n;

    assert_inuse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        !$past(msix_on) |-> $stable(in_use));

    assert_inuse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        !$past(use_valid) |-> $stable(in_use));

endmodule

// File: rtl/irq_target_map.sv
// Module: holds the conditional-steering bit and computes the interrupter
// an event is steered to.
// Assumes: intr_count is static during normal operation.
module irq_target_map #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_cond_map,
    input  logic [IDX_W:0]   intr_count,
    input  logic             msg_mode_on,
    input  logic [IDX_W-1:0] evt_target,
    output logic [IDX_W-1:0] eff_target
);

    logic cond_q;
    logic map_on;
    logic started_q;

    // Hold the conditional-steering configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      cond_q <= 1'b0;
        else if (cfg_we) cond_q <= cfg_cond_map;
    end

    // Steering is on with several interrupters, unless gated to message modes.
    always_comb begin
        map_on     = (intr_count > (IDX_W+1)'(1)) && (!cond_q || msg_mode_on);
        eff_target = map_on ? evt_target : '0;
    end

    // Track that a reset cycle has been seen, for the assertions below.
    always_ff @(posedge clk) started_q <= started_q | !rst_n;

    assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        (intr_count == (IDX_W+1)'(1)) |-> (eff_target == '0));

    assert_cond_pin_R7: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        ($past(cfg_we && cfg_cond_map) && !$past(msg_mode_on) && !msg_mode_on) |-> (eff_target == '0));

endmodule

// File: rtl/irq_router.sv
// Module: top of the interrupt delivery router. Selects pin, MSI-X or MSI
// delivery, drives the legacy pin, and instantiates the arbiter, the in-use
// bitmap and the target steering.
// Assumes: msi_vec_log2 above 5 behaves as 5.
module irq_router
    import irq_router_pkg::*;
#(
    parameter  int NUM_INTR = 8,
    localparam int IDX_W    = (NUM_INTR > 1) ? $clog2(NUM_INTR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msix_en,
    input  logic                msi_en,
    input  logic [2:0]          msi_vec_log2,
    input  logic [IDX_W:0]      intr_count,
    input  logic                cfg_we,
    input  logic                cfg_cond_map,
    input  logic [NUM_INTR-1:0] raise_pulse,
    input  logic [NUM_INTR-1:0] raise_level,
    output logic [NUM_INTR-1:0] raise_delivered,
    output logic                irq_pin,
    output logic                msg_valid,
    output logic [IDX_W-1:0]    msg_vector,
    input  logic                use_valid,
    input  logic [IDX_W-1:0]    use_idx,
    input  logic                use_enable,
    output logic [NUM_INTR-1:0] vec_in_use,
    input  logic [IDX_W-1:0]    evt_target,
    output logic [IDX_W-1:0]    eff_target
);

    dlv_mode_e           mode;
    logic [IDX_W-1:0]    msi_mask;
    logic [2:0]          lg_clamped;
    logic [NUM_INTR-1:0] accepted;
    logic                started_q;

    // Decode the delivery mode and the MSI vector mask.
    always_comb begin
        mode       = pick_mode(msix_en, msi_en);
        lg_clamped = (msi_vec_log2 > 3'(MSI_LOG2_MAX)) ? 3'(MSI_LOG2_MAX) : msi_vec_log2;
        msi_mask   = IDX_W'((32'd1 << lg_clamped) - 32'd1);
    end

    // Accept asserted requests only when a message mode is active.
    always_comb begin
        accepted        = raise_pulse & raise_level & {NUM_INTR{mode != DLV_PIN}};
        raise_delivered = accepted;
    end

    // Legacy pin follows interrupter 0's level in pin mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                             irq_pin <= 1'b0;
        else if (mode == DLV_PIN && raise_pulse[0]) irq_pin <= raise_level[0];
    end

    irq_msg_arb #(.NUM_INTR(NUM_INTR), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .msi_mask  (msi_mask),
        .new_req   (accepted),
        .msg_valid (msg_valid),
        .msg_vector(msg_vector)
    );

    irq_vec_use #(.NUM_INTR(NUM_INTR), .IDX_W(IDX_W)) u_use (
        .clk       (clk),
        .rst_n     (rst_n),
        .msix_on   (msix_en),
        .use_valid (use_valid),
        .use_idx   (use_idx),
        .use_enable(use_enable),
        .in_use    (vec_in_use)
    );

    irq_target_map #(.IDX_W(IDX_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_cond_map(cfg_cond_map),
        .intr_count  (intr_count),
        .msg_mode_on (msix_en | msi_en),
        .evt_target  (evt_target),
        .eff_target  (eff_target)
    );

    // Track that a reset cycle has been seen, for the assertions below.
    always_ff @(posedge clk) started_q <= started_q | !rst_n;

    assert_pin_source_R1: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        $rose(irq_pin) |-> $past(!msix_en && !msi_en && raise_pulse[0] && raise_level[0]));

    assert_pin_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        !$past(raise_pulse[0]) |-> $stable(irq_pin));

    assert_low_undelivered_R4: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
        ((raise_delivered & ~raise_level) == '0));

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
    localparam int N = 8;
    localparam int W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msix_en = 0, msi_en = 0;
    logic [2:0] msi_vec_log2 = 0;
    logic [W:0] intr_count = 4'd8;
    logic cfg_we = 0, cfg_cond_map = 0;
    logic [N-1:0] raise_pulse = '0, raise_level = '0;
    logic [N-1:0] raise_delivered;
    logic irq_pin, msg_valid;
    logic [W-1:0] msg_vector;
    logic use_valid = 0, use_enable = 0;
    logic [W-1:0] use_idx = '0;
    logic [N-1:0] vec_in_use;
    logic [W-1:0] evt_target = '0;
    logic [W-1:0] eff_target;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_router #(.NUM_INTR(N)) uut (
        .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .msi_en(msi_en),
        .msi_vec_log2(msi_vec_log2), .intr_count(intr_count),
        .cfg_we(cfg_we), .cfg_cond_map(cfg_cond_map),
        .raise_pulse(raise_pulse), .raise_level(raise_level),
        .raise_delivered(raise_delivered), .irq_pin(irq_pin),
        .msg_valid(msg_valid), .msg_vector(msg_vector),
        .use_valid(use_valid), .use_idx(use_idx), .use_enable(use_enable),
        .vec_in_use(vec_in_use), .evt_target(evt_target), .eff_target(eff_target)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each message strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected message", int'(msg_vector), -1);
            end else begin
                check(tag_q.pop_front(), int'(msg_vector), exp_q.pop_front());
            end
        end
    end

    // Driver: pulse requests for one cycle and push the expected vectors.
    task automatic pulse(input logic [N-1:0] m, input logic [N-1:0] lvl, input string tag);
        logic [N-1:0] exp_dlv;
        @(negedge clk);
        raise_pulse = m;
        raise_level = lvl;
        exp_dlv = (msix_en || msi_en) ? (m & lvl) : '0;
        for (int i = 0; i < N; i++) begin
            if (exp_dlv[i]) begin
                exp_q.push_back(msix_en ? i : i % (1 << msi_vec_log2));
                tag_q.push_back(tag);
            end
        end
        #1 check("R4 delivered", int'(raise_delivered), int'(exp_dlv));
        @(negedge clk);
        raise_pulse = '0;
        raise_level = '0;
    endtask

    task automatic drain(input string tag);
        repeat (N + 2) @(negedge clk);
        check(tag, exp_q.size(), 0);
    endtask

    task automatic use_req(input int idx, input logic en);
        @(negedge clk);
        use_valid = 1; use_idx = W'(idx); use_enable = en;
        @(negedge clk);
        use_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check("R10 pin after reset", irq_pin, 0);
        check("R10 in-use after reset", int'(vec_in_use), 0);
        check("R10 strobe after reset", msg_valid, 0);
        // R8 steering bit off after reset: target passes in pin mode
        evt_target = 3'd5; #1;
        check("R8 target with bit cleared", eff_target, 5);

        // R1 pin mode
        pulse(8'h01, 8'h01, "R1");
        check("R1 pin set", irq_pin, 1);
        pulse(8'h08, 8'h08, "R1");
        check("R1 other interrupter ignored", irq_pin, 1);
        pulse(8'h01, 8'h00, "R1");
        check("R1 pin cleared by low level", irq_pin, 0);
        drain("R1 no message in pin mode");

        // R2 / R5 MSI-X, several at once, ascending order
        msix_en = 1;
        pulse(8'hA4, 8'hA4, "R5 order");
        drain("R5 queue drained");
        msi_en = 1; msi_vec_log2 = 3'd1;
        pulse(8'h20, 8'h20, "R2 MSI-X priority");
        drain("R2 queue drained");

        // R3 MSI only
        msix_en = 0; msi_vec_log2 = 3'd2;
        pulse(8'h40, 8'h40, "R3 modulo 4");
        pulse(8'h08, 8'h08, "R3 modulo 4");
        drain("R3 drained");
        msi_vec_log2 = 3'd0;
        pulse(8'h80, 8'h80, "R3 single vector");
        drain("R3 drained single");

        // R4 deassert in message mode
        msi_en = 0; msix_en = 1;
        pulse(8'h10, 8'h00, "R4");
        drain("R4 no message on low level");

        // R9 in-use tracking
        msix_en = 0;
        use_req(3, 1);
        check("R9 ignored while MSI-X off", int'(vec_in_use), 0);
        msix_en = 1;
        use_req(3, 1);
        check("R9 set", int'(vec_in_use), 8);
        use_req(3, 1);
        check("R9 matching request no change", int'(vec_in_use), 8);
        use_req(3, 0);
        check("R9 cleared", int'(vec_in_use), 0);
        use_req(6, 1);

        // R6 single interrupter
        intr_count = 4'd1; #1;
        check("R6 single interrupter", eff_target, 0);
        intr_count = 4'd8;
        // R7 conditional steering
        @(negedge clk); cfg_we = 1; cfg_cond_map = 1;
        @(negedge clk); cfg_we = 0; cfg_cond_map = 0;
        msix_en = 0; msi_en = 0; #1;
        check("R7 pin mode forces 0", eff_target, 0);
        msi_en = 1; #1;
        check("R7 MSI passes target", eff_target, 5);
        msi_en = 0; msix_en = 1; #1;
        check("R7 MSI-X passes target", eff_target, 5);

        // R10 mid-run reset
        msix_en = 0;
        pulse(8'h01, 8'h01, "R10");
        check("R10 pin set before reset", irq_pin, 1);
        do_reset();
        check("R10 pin cleared", irq_pin, 0);
        check("R10 in-use cleared", int'(vec_in_use), 0);
        msix_en = 0; #1;
        check("R8 bit cleared by reset", eff_target, 5);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            check("watchdog", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule